// File: doc/BRIEF.md
# Sampling Converter Bus Control

This block is the digital sequencer and read port of a 12-bit sampling converter. It runs on a single clock. Three asynchronous control lines drive it: an active-low chip select, a read/convert line and a high-byte select. Each line passes through a two-flop synchronizer before any logic uses it. A conversion begins only when the synchronized read/convert line falls while the chip is selected and the high-byte select is low. A cycle counter then takes the place of the converter's internal clock. During the conversion the active-low busy flag is held low and all control activity is ignored.

The sample port is captured when the conversion begins. The captured value moves into the result register only when the conversion count expires. The result can be read in two ways. With the byte select low, it comes out as a full 12-bit word. With the byte select high, the upper bits come out as a zero-extended byte for an 8-bit bus. The block does not drive real three-state pads. It produces an output-enable signal and forces the data bus to zero whenever reading is not allowed. Two styles of operation are supported. In convert mode, a low-going pulse starts a conversion and the data is read after busy rises. In read mode, the previous result is read while read/convert is high, and the falling edge starts the next conversion.

Top module: `adc_bus_ctrl`

## Requirements
- R1: A conversion starts only after a high-to-low transition of the synchronized read/convert line. No steady level and no rising edge starts one.
- R2: A falling edge does not start a conversion if chip select (`sel_n`) is high or `byte_hi` is high in the edge cycle. It also does not start one while busy is low.
- R3: `busy_n` is low for exactly CONV_CYC consecutive cycles per conversion and high at all other times. CONV_CYC = ceil(CONV_NS*CLK_MHZ/1000).
- R4: While `busy_n` is low, `data_oe` is low. All changes on `sel_n`, `rd_cnv` and `byte_hi` are ignored, so a conversion is neither cut short nor restarted, and no conversion starts afterwards from an edge that occurred while busy.
- R5: `data_oe` is high only when the synchronized `rd_cnv` is high, the synchronized `sel_n` is low and `busy_n` is high. When `data_oe` is low, `data_out` is all zeros.
- R6: On a read with `byte_hi` low, `data_out` carries the full 12-bit result. With `byte_hi` high, `data_out[3:0]` carries result bits 11:8 and bits 11:4 are zero.
- R7: Both operating styles work. In convert mode, a low pulse that returns high during the conversion gives readable data after `busy_n` rises. In read mode, the earlier result is readable while `rd_cnv` is high, and the next falling edge starts a new conversion.
- R8: Two timing rules apply, with LOW_CYC = ceil(LOW_NS*CLK_MHZ/1000) and SETUP_CYC = ceil(SETUP_NS*CLK_MHZ/1000).
  - The synchronized `rd_cnv` must stay low for LOW_CYC cycles, counting the edge cycle. A shorter low pulse starts nothing.
  - Chip select and `byte_hi` must both have been low for SETUP_CYC synchronized cycles before the edge.
  - With `rd_cnv` driven low, `busy_n` falls after LOW_CYC+2 clock edges.
- R9: The conversion length comes from the parameter CONV_NS. Values of 2700, 4700 and 9700 represent the three model variants.
- R10: `sample_in` is captured in the cycle `busy_n` falls. The result register changes only when `busy_n` rises, and takes that captured value. Changes to `sample_in` during the conversion do not affect the result.
- R11: After reset, `busy_n` is high, `data_oe` is low and the result register reads as zero.
- R12: A change on `sel_n`, `rd_cnv` or `byte_hi` reaches `data_oe`/`data_out` exactly two clock edges after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| rd_cnv | input | 1 | Read (high) / convert (falling edge), asynchronous |
| byte_hi | input | 1 | High-byte select for 8-bit bus reads, asynchronous |
| sample_in | input | DATA_W | Abstract converter sample |
| busy_n | output | 1 | Low only while a conversion runs |
| data_oe | output | 1 | Data output enable (stands in for three-state control) |
| data_out | output | DATA_W | Result or high byte; zero when not enabled |

## Verification
A wrong sequencer state shows up at `busy_n` within one cycle:

- A missed qualifier shows as a falling edge that should not occur.
- A miscounted width or length shows as a busy-low run of the wrong length.
- An edge acted on during busy shows as a spurious second run.

A result register loaded at the wrong time shows up as the wrong word on the first enabled read after `busy_n` rises. Faults in the read gating or byte steering show up on `data_oe`/`data_out` two edges after the control inputs change, which matches the synchronizer depth. A per-cycle reference model exposes all of these in the first cycle they occur.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  // Sequencer phase
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARM  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;

  // Convert a time in ns to clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Width of a counter that must hold the value n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_start_qual.sv
module adc_start_qual #(
  parameter int SETUP_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rc_s,
  input  logic sel_s,
  input  logic hb_s,
  output logic fall_evt,
  output logic setup_ok
);
  import adc_ctrl_pkg::*;

  localparam int CW = cnt_w(SETUP_CYC);

  logic          rc_q;
  logic [CW-1:0] quiet_run;

  // previous synchronized read/convert level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc_q <= 1'b1;
    else        rc_q <= rc_s;
  end

  // run of cycles with select asserted and byte select low, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      quiet_run <= '0;
    else if (sel_s || hb_s)
      quiet_run <= '0;
    else if (quiet_run != CW'(SETUP_CYC))
      quiet_run <= quiet_run + 1'b1;
  end

  assign fall_evt = rc_q & ~rc_s;
  assign setup_ok = (quiet_run == CW'(SETUP_CYC));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W   = 12,
  parameter int LOW_CYC  = 10,
  parameter int CONV_CYC = 675
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic              setup_ok,
  input  logic              rc_s,
  input  logic              sel_s,
  input  logic              hb_s,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy_n,
  output logic              go_evt,
  output logic              start_evt,
  output logic              done_evt,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] result
);
  import adc_ctrl_pkg::*;

  localparam int LW = cnt_w(LOW_CYC);
  localparam int KW = cnt_w(CONV_CYC);

  phase_e        ph;
  logic [LW-1:0] low_cnt;
  logic [KW-1:0] conv_cnt;
  logic          arm_abort;

  assign go_evt    = (ph == PH_IDLE) & fall_evt & setup_ok & ~sel_s & ~hb_s;
  assign arm_abort = (ph == PH_ARM) & rc_s;
  assign start_evt = (ph == PH_ARM) & ~rc_s & (low_cnt == LW'(LOW_CYC - 1));
  assign done_evt  = (ph == PH_CONV) & (conv_cnt == KW'(CONV_CYC - 1));
  assign busy_n    = (ph != PH_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      low_cnt  <= '0;
      conv_cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (go_evt) begin
          ph      <= PH_ARM;
          low_cnt <= LW'(1);
        end
        PH_ARM: begin
          if (arm_abort)      ph <= PH_IDLE;
          else if (start_evt) begin
            ph       <= PH_CONV;
            conv_cnt <= '0;
          end else            low_cnt <= low_cnt + 1'b1;
        end
        PH_CONV: begin
          if (done_evt) ph <= PH_IDLE;
          else          conv_cnt <= conv_cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // sample capture at start, result commit at expiry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      result <= '0;
    end else begin
      if (start_evt) held   <= sample_in;
      if (done_evt)  result <= held;
    end
  end

endmodule

// File: rtl/adc_read_port.sv
module adc_read_port #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              rc_s,
  input  logic              sel_s,
  input  logic              hb_s,
  input  logic              busy_n,
  input  logic [DATA_W-1:0] result,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out
);

  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] view;

  assign data_oe = rc_s & ~sel_s & busy_n;

  always_comb begin
    if (hb_s) begin
      view           = '0;
      view[HI_W-1:0] = result[DATA_W-1:BYTE_W];
    end else begin
      view = result;
    end
  end

  assign data_out = data_oe ? view : '0;

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int CLK_MHZ     = 250,
  parameter int CONV_NS     = 2700,
  parameter int LOW_NS      = 40,
  parameter int SETUP_NS    = 25,
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_cnv,
  input  logic              byte_hi,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy_n,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out
);
  import adc_ctrl_pkg::*;

  localparam int CONV_CYC  = ns_to_cyc(CONV_NS, CLK_MHZ);
  localparam int LOW_CYC   = ns_to_cyc(LOW_NS, CLK_MHZ);
  localparam int SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_MHZ);

  // synchronized controls: [2] read/convert, [1] select, [0] byte select
  logic [2:0]        ctl_s;
  logic              rc_s, sel_s, hb_s;
  logic              fall_evt, setup_ok;
  logic              go_evt, start_evt, done_evt;
  logic [DATA_W-1:0] held_q, result_q;

  adc_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({rd_cnv, sel_n, byte_hi}),
    .q    (ctl_s)
  );

  assign rc_s  = ctl_s[2];
  assign sel_s = ctl_s[1];
  assign hb_s  = ctl_s[0];

  adc_start_qual #(
    .SETUP_CYC(SETUP_CYC)
  ) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .rc_s    (rc_s),
    .sel_s   (sel_s),
    .hb_s    (hb_s),
    .fall_evt(fall_evt),
    .setup_ok(setup_ok)
  );

  adc_conv_seq #(
    .DATA_W  (DATA_W),
    .LOW_CYC (LOW_CYC),
    .CONV_CYC(CONV_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_evt (fall_evt),
    .setup_ok (setup_ok),
    .rc_s     (rc_s),
    .sel_s    (sel_s),
    .hb_s     (hb_s),
    .sample_in(sample_in),
    .busy_n   (busy_n),
    .go_evt   (go_evt),
    .start_evt(start_evt),
    .done_evt (done_evt),
    .held     (held_q),
    .result   (result_q)
  );

  adc_read_port #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
  ) u_read (
    .rc_s    (rc_s),
    .sel_s   (sel_s),
    .hb_s    (hb_s),
    .busy_n  (busy_n),
    .result  (result_q),
    .data_oe (data_oe),
    .data_out(data_out)
  );

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int CONV_CYC = 675,
  parameter int DATA_W   = 12,
  parameter int BYTE_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_n,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out,
  input logic              hb_s,
  input logic [DATA_W-1:0] sample_in,
  input logic [DATA_W-1:0] held,
  input logic [DATA_W-1:0] result
);

  localparam int HI_W = DATA_W - BYTE_W;

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= 0;
    else if (!busy_n) low_run <= low_run + 1;
    else              low_run <= 0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_run == CONV_CYC));

  // R4
  oe_off_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !data_oe);

  // R5
  bus_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  // R6
  hi_byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && hb_s) |-> (data_out[DATA_W-1:HI_W] == '0));

  // R10
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> (held == $past(sample_in)));

  // R10
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(busy_n));

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(
  .CONV_CYC(CONV_CYC),
  .DATA_W  (DATA_W),
  .BYTE_W  (BYTE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_n   (busy_n),
  .data_oe  (data_oe),
  .data_out (data_out),
  .hb_s     (hb_s),
  .sample_in(sample_in),
  .held     (held_q),
  .result   (result_q)
);

// File: tb/test_adc_bus_ctrl.sv
`timescale 1ns/1ps
module test_adc_bus_ctrl;

  localparam int CLK_MHZ  = 250;
  localparam int CONV_NS  = 400;
  localparam int LOW_CYC  = (40 * CLK_MHZ + 999) / 1000;      // 10
  localparam int SETUP    = (25 * CLK_MHZ + 999) / 1000;      // 7
  localparam int CONV     = (CONV_NS * CLK_MHZ + 999) / 1000; // 100

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        rd_cnv = 1'b1;
  logic        byte_hi = 1'b0;
  logic [11:0] sample_in = '0;
  logic        busy_n, data_oe;
  logic [11:0] data_out;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_bus_ctrl #(.CLK_MHZ(CLK_MHZ), .CONV_NS(CONV_NS)) i_adc_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_cnv(rd_cnv),
    .byte_hi(byte_hi), .sample_in(sample_in), .busy_n(busy_n),
    .data_oe(data_oe), .data_out(data_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [2:0]  hist[$];          // {rd, sel, hb} seen at each edge
  int          mode;             // 0 idle, 1 waiting for width, 2 converting
  int          quiet, lowc, convc;
  logic [11:0] m_held, m_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{3'b110, 3'b110, 3'b110};
      mode = 0; quiet = 0; lowc = 0; convc = 0;
      m_held = '0; m_res = '0;
    end else begin
      logic [2:0] now_v, prev_v;
      bit ok;
      now_v  = hist[hist.size()-2];
      prev_v = hist[hist.size()-3];
      ok = (quiet >= SETUP);
      if (mode == 0) begin
        if (prev_v[2] && !now_v[2] && ok && !now_v[1] && !now_v[0]) begin
          mode = 1; lowc = 1;
        end
      end else if (mode == 1) begin
        if (now_v[2]) mode = 0;
        else if (lowc + 1 >= LOW_CYC) begin mode = 2; m_held = sample_in; convc = 0; end
        else lowc++;
      end else begin
        convc++;
        if (convc == CONV) begin mode = 0; m_res = m_held; end
      end
      quiet = (now_v[1] || now_v[0]) ? 0 : quiet + 1;
      hist.push_back({rd_cnv, sel_n, byte_hi});
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0]  v;
      logic        e_busy, e_oe;
      logic [11:0] e_data;
      v      = hist[hist.size()-2];
      e_busy = (mode != 2);
      e_oe   = v[2] && !v[1] && e_busy;
      e_data = !e_oe ? 12'h000 : (v[0] ? {8'h00, m_res[11:8]} : m_res);
      chk(busy_n === e_busy, "R3 model busy_n", busy_n, e_busy);
      chk(data_oe === e_oe, "R5 model data_oe", data_oe, e_oe);
      chk(data_out === e_data, "R6 model data_out", data_out, e_data);
    end
  end

  // busy-run monitor
  int run_low = 0, last_low = 0, nconv = 0;
  always @(posedge clk) begin
    if (!rst_n) begin run_low = 0; nconv = 0; end
    else if (!busy_n) run_low++;
    else if (run_low > 0) begin last_low = run_low; nconv++; run_low = 0; end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!busy_n && guard < 5000) begin tick(1); guard++; end
    tick(1);
  endtask

  initial begin
    int c0;
    tick(5);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    chk(busy_n === 1'b1, "R11 busy_n after reset", busy_n, 1);
    chk(data_oe === 1'b0, "R11 data_oe after reset", data_oe, 0);
    sel_n = 1'b0;
    tick(1);
    chk(data_oe === 1'b0, "R12 one edge after select", data_oe, 0);
    tick(1);
    chk(data_oe === 1'b1, "R12 two edges after select", data_oe, 1);
    chk(data_out === 12'h000, "R11 result cleared", data_out, 0);

    // convert mode: low pulse returning high during conversion (R1, R7, R8)
    tick(10);
    sample_in = 12'hA5C;
    c0 = nconv;
    rd_cnv = 1'b0;
    tick(LOW_CYC + 1);
    chk(busy_n === 1'b1, "R8 busy still high before width met", busy_n, 1);
    tick(1);
    chk(busy_n === 1'b0, "R1 busy low after falling edge", busy_n, 0);
    rd_cnv = 1'b1;
    sample_in = 12'h111;   // R10 change after capture
    wait_idle();
    chk(data_out === 12'hA5C, "R7 convert mode read / R10 captured", data_out, 12'hA5C);
    chk(last_low == CONV, "R9 conversion length", last_low, CONV);
    chk(nconv == c0 + 1, "R1 one conversion", nconv, c0 + 1);

    // R2 blocked by select high
    sel_n = 1'b1; tick(10);
    c0 = nconv;
    rd_cnv = 1'b0; tick(LOW_CYC + 4); rd_cnv = 1'b1;
    tick(CONV + 20);
    chk(nconv == c0, "R2 select high blocks start", nconv, c0);
    sel_n = 1'b0;

    // R2 blocked by byte select high
    byte_hi = 1'b1; tick(10);
    rd_cnv = 1'b0; tick(LOW_CYC + 4); rd_cnv = 1'b1;
    tick(CONV + 20);
    chk(nconv == c0, "R2 byte select high blocks start", nconv, c0);
    byte_hi = 1'b0; tick(10);

    // R8 short low pulse
    rd_cnv = 1'b0; tick(LOW_CYC - 3); rd_cnv = 1'b1;
    tick(CONV + 20);
    chk(nconv == c0, "R8 short pulse starts nothing", nconv, c0);
    chk(busy_n === 1'b1, "R8 busy high after short pulse", busy_n, 1);

    // R8 setup too short
    sel_n = 1'b1; tick(10);
    sel_n = 1'b0; tick(3);
    rd_cnv = 1'b0; tick(LOW_CYC + 4); rd_cnv = 1'b1;
    tick(CONV + 20);
    chk(nconv == c0, "R8 setup violation starts nothing", nconv, c0);

    // R4 activity during busy is ignored
    tick(10);
    sample_in = 12'h9E1;
    rd_cnv = 1'b0; tick(LOW_CYC + 4); rd_cnv = 1'b1;
    tick(3);
    rd_cnv = 1'b0; tick(5);
    sel_n = 1'b1; byte_hi = 1'b1; tick(5);
    rd_cnv = 1'b1; tick(5);
    chk(data_oe === 1'b0, "R4 outputs off while busy", data_oe, 0);
    rd_cnv = 1'b0; sel_n = 1'b0; byte_hi = 1'b0; tick(5);
    chk(busy_n === 1'b0, "R4 conversion not aborted", busy_n, 0);
    wait_idle();
    tick(CONV + 20);
    chk(nconv == c0 + 1, "R4 no restart from edges while busy", nconv, c0 + 1);
    chk(last_low == CONV, "R4 full-length conversion", last_low, CONV);
    chk(data_oe === 1'b0, "R5 read/convert low keeps outputs off", data_oe, 0);

    // R7 read mode: previous result readable while high
    sample_in = 12'h3C7;
    rd_cnv = 1'b1; tick(3);
    chk(data_out === 12'h9E1, "R7 read mode shows previous result", data_out, 12'h9E1);
    byte_hi = 1'b1; tick(2);
    chk(data_out === 12'h009, "R6 high byte on 8-bit bus", data_out, 12'h009);
    byte_hi = 1'b0; tick(10);
    rd_cnv = 1'b0; tick(LOW_CYC + 2);
    chk(busy_n === 1'b0, "R7 falling edge starts next conversion", busy_n, 0);
    wait_idle();
    rd_cnv = 1'b1; tick(2);
    chk(data_out === 12'h3C7, "R7 new result readable", data_out, 12'h3C7);
    chk(data_oe === 1'b1, "R5 enabled when all three hold", data_oe, 1);
    sel_n = 1'b1; tick(2);
    chk(data_oe === 1'b0, "R5 deselect disables", data_oe, 0);
    chk(data_out === 12'h000, "R5 disabled bus is zero", data_out, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule